// File: doc/BRIEF.md
# Waveform-Generating 8-Bit Timer/Counter

An 8-bit counter that steps once for every cycle on which its count-enable strobe is high. A 3-bit mode field selects how it counts. It can run free, it can clear when it equals compare value A, it can run as a single-slope PWM, or it can run as a dual-slope up/down PWM. The upper limit (TOP) is either 0xFF or compare value A, depending on the mode.

Two compare channels, A and B, each keep a written value and an active value. Each channel drives a waveform output and an output enable, and a 2-bit output-action code per channel selects the behaviour. Three sticky flags report events: one for overflow and one for each compare match. Software clears a flag by writing a one to it.

Registers are written through a simple port. Address 0 holds the control word, address 1 compare value A, address 2 compare value B, and address 3 is the flag-clear word.

Top module: `wave_timer8`

## Requirements
- R1: Control word layout: bits [2:0] select the mode, bits [5:4] hold the output-action code of A, and bits [7:6] hold that of B. After reset the counter, both compare values, the control word, the flags and both outputs are 0, and the count direction is up.
- R2: The counter changes only on cycles where `tick` is high. Every result below appears on the first cycle after the count step that causes it.
- R3: Modes 0, 4 and 6 count 0x00 to 0xFF and wrap to 0x00. The overflow flag sets on the step taken while the counter is at 0xFF.
- R4: In mode 2 the counter returns to 0x00 on the step taken while it equals active compare value A, so the period is A+1 steps. Overflow sets only on a step at 0xFF.
- R5: Modes 3 (TOP 0xFF) and 7 (TOP = compare A) return to 0x00 on the step taken at TOP. Overflow sets on the step at 0xFF in mode 3 and on the step at TOP in mode 7.
- R6: Modes 1 (TOP 0xFF) and 5 (TOP = compare A) count up to TOP and then down to 0x00. Each extreme is held for a single step. Overflow sets on the step taken at 0x00.
- R7: In modes 0, 2, 4 and 6 a compare write becomes active at once. In modes 1, 3, 5 and 7 the written value becomes active on the step taken at TOP. In single-slope modes that step is the one where the counter returns to BOTTOM.
- R8: The flag for channel A or B sets on a step where the counter equals that channel's active compare value. A flag stays set until a write to address 3 with bit 1 (A), bit 2 (B) or bit 3 (overflow) high. A set in the same cycle wins, and flags not selected by the write are kept.
- R9: In modes 0, 2, 4 and 6, output-action codes act on a match as follows: 00 leaves the pin disconnected, 01 toggles, 10 clears and 11 sets.
- R10: In modes 3 and 7, code 10 clears the output on a match and sets it on the step at TOP. The step-at-TOP action wins when both happen together. Code 11 does the inverse. Codes 00 and 01 disconnect the pin (enable low).
- R11: In modes 1 and 5, code 10 clears the output on a match while counting up and sets it on a match while counting down. A match at 0x00 counts as up. Code 11 does the inverse. Codes 00 and 01 disconnect the pin.
- R12: In modes 1 and 5, when a channel's compare value equals TOP and its code is 1x, the match action is not used. Instead the step at TOP sets the output for code 10 and clears it for code 11. The compare flag still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 compare A, 2 compare B, 3 flag clear) |
| wr_data | input | 8 | Register write data |
| count | output | 8 | Current counter value |
| out_a | output | 1 | Channel A waveform |
| out_b | output | 1 | Channel B waveform |
| oe_a | output | 1 | Channel A output enable |
| oe_b | output | 1 | Channel B output enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmpa_flag | output | 1 | Sticky compare-A flag |
| cmpb_flag | output | 1 | Sticky compare-B flag |

## Verification
Every counter, flag and waveform result is due on the cycle after the count step that produces it. The bench numbers steps from the cycle on which the strobe is raised, so step k is complete after k rising edges. Each expected value is queued against that absolute cycle and compared at the following falling edge. Output enables and register writes take effect one edge after the write is presented, and their checks are scheduled the same way.

// File: rtl/wave_timer8.sv
module wave_timer8 #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  count,
  output logic          out_a,
  output logic          out_b,
  output logic          oe_a,
  output logic          oe_b,
  output logic          ovf_flag,
  output logic          cmpa_flag,
  output logic          cmpb_flag
);
  localparam logic [W-1:0]  MAXV      = '1;
  localparam logic [W-1:0]  BOTV      = '0;
  localparam logic [AW-1:0] ADR_CTRL  = AW'(0);
  localparam logic [AW-1:0] ADR_CMPA  = AW'(1);
  localparam logic [AW-1:0] ADR_CMPB  = AW'(2);
  localparam logic [AW-1:0] ADR_FLAGS = AW'(3);

  logic [2:0]   mode;
  logic [1:0]   com_a, com_b;
  logic [W-1:0] buf_a, buf_b, act_a, act_b;
  logic         dir_dn;

  logic         is_pc, is_fast, is_pwm, top_from_a;
  logic [W-1:0] top;
  logic         at_top, at_bot, up_now, top_step, load;
  logic         hit_a, hit_b, ovf_evt, clr;
  logic [W-1:0] nxt;

  assign is_pc      = (mode == 3'd1) || (mode == 3'd5);
  assign is_fast    = (mode == 3'd3) || (mode == 3'd7);
  assign is_pwm     = is_pc || is_fast;
  assign top_from_a = (mode == 3'd2) || (mode == 3'd5) || (mode == 3'd7);
  assign top        = top_from_a ? act_a : MAXV;
  assign at_top     = count == top;
  assign at_bot     = count == BOTV;
  assign up_now     = at_bot ? 1'b1 : (at_top ? 1'b0 : !dir_dn);
  assign top_step   = tick && at_top;
  assign load       = top_step && is_pwm;
  assign hit_a      = tick && (count == act_a);
  assign hit_b      = tick && (count == act_b);
  assign clr        = wr_en && (wr_addr == ADR_FLAGS);

  assign ovf_evt = tick && (is_pc ? at_bot : ((mode == 3'd7) ? at_top : (count == MAXV)));

  always_comb begin
    if (is_pc)
      nxt = (top == BOTV) ? BOTV : (up_now ? count + 1'b1 : count - 1'b1);
    else if ((mode == 3'd2 || is_fast) && at_top)
      nxt = BOTV;
    else
      nxt = count + 1'b1;
  end

  assign oe_a = (com_a != 2'b00) && !(is_pwm && com_a == 2'b01);
  assign oe_b = (com_b != 2'b00) && !(is_pwm && com_b == 2'b01);

  function automatic logic next_wave(input logic cur, input logic [1:0] com, input logic hit,
                                     input logic tstep, input logic up, input logic pc,
                                     input logic fast, input logic eq_top);
    logic r;
    r = cur;
    if (com != 2'b00) begin
      if (pc) begin
        if (com[1]) begin
          if (eq_top) begin
            if (tstep) r = ~com[0];
          end else if (hit) begin
            r = up ? com[0] : ~com[0];
          end
        end
      end else if (fast) begin
        if (com[1]) begin
          if (tstep)    r = ~com[0];
          else if (hit) r = com[0];
        end
      end else if (hit) begin
        r = com[1] ? com[0] : ~cur;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      com_a <= '0;
      com_b <= '0;
      buf_a <= '0;
      buf_b <= '0;
      act_a <= '0;
      act_b <= '0;
    end else begin
      if (wr_en && wr_addr == ADR_CTRL) begin
        mode  <= wr_data[2:0];
        com_a <= wr_data[5:4];
        com_b <= wr_data[7:6];
      end
      if (wr_en && wr_addr == ADR_CMPA) buf_a <= wr_data;
      if (wr_en && wr_addr == ADR_CMPB) buf_b <= wr_data;
      if (!is_pwm) begin
        act_a <= (wr_en && wr_addr == ADR_CMPA) ? wr_data : buf_a;
        act_b <= (wr_en && wr_addr == ADR_CMPB) ? wr_data : buf_b;
      end else if (load) begin
        act_a <= buf_a;
        act_b <= buf_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      dir_dn <= 1'b0;
      out_a  <= 1'b0;
      out_b  <= 1'b0;
    end else if (tick) begin
      count  <= nxt;
      dir_dn <= is_pc && !up_now;
      out_a  <= next_wave(out_a, com_a, hit_a, top_step, up_now, is_pc, is_fast, act_a == top);
      out_b  <= next_wave(out_b, com_b, hit_b, top_step, up_now, is_pc, is_fast, act_b == top);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      cmpa_flag <= 1'b0;
      cmpb_flag <= 1'b0;
    end else begin
      cmpa_flag <= hit_a   || (cmpa_flag && !(clr && wr_data[1]));
      cmpb_flag <= hit_b   || (cmpb_flag && !(clr && wr_data[2]));
      ovf_flag  <= ovf_evt || (ovf_flag  && !(clr && wr_data[3]));
    end
  end
endmodule

module wave_timer8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [2:0] mode,
  input logic [1:0] com_b,
  input logic [7:0] count,
  input logic [7:0] cmp_a,
  input logic       ovf_flag,
  input logic       cmpa_flag,
  input logic       out_b,
  input logic       oe_b
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 3'd0 && count == 8'hFF) |=> (count == 8'h00 && ovf_flag));
  p_ctc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 3'd2 && count == cmp_a) |=> (count == 8'h00));
  p_fast_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 3'd7 && count == cmp_a) |=> (count == 8'h00 && ovf_flag));
  p_pc_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 3'd1 && count == 8'h00) |=> (count == 8'h01 && ovf_flag));
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpa_flag && !(wr_en && wr_addr == 2'd3 && wr_data[1])) |=> cmpa_flag);
  p_fast_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 3'd3 && count == 8'hFF && com_b == 2'b10) |=> out_b);
  p_fast_disc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && com_b == 2'b01) |-> !oe_b);
endmodule

bind wave_timer8 wave_timer8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .mode(mode), .com_b(com_b), .count(count), .cmp_a(act_a),
  .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag), .out_b(out_b), .oe_b(oe_b)
);

// File: tb/wave_timer8_test.sv
module wave_timer8_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count;
  logic       out_a, out_b, oe_a, oe_b, ovf_flag, cmpa_flag, cmpb_flag;

  localparam int S_CNT = 0, S_OA = 1, S_OB = 2, S_OVF = 3, S_FA = 4, S_FB = 5, S_EA = 6, S_EB = 7;

  int cyc = 0;
  int t0 = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    due_q[$];
  int    sel_q[$];
  int    exp_q[$];
  string req_q[$];

  always #5 clk = ~clk;

  wave_timer8 uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .out_a(out_a), .out_b(out_b), .oe_a(oe_a),
    .oe_b(oe_b), .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag), .cmpb_flag(cmpb_flag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pick(input int sel);
    case (sel)
      S_CNT:   return int'(count);
      S_OA:    return int'(out_a);
      S_OB:    return int'(out_b);
      S_OVF:   return int'(ovf_flag);
      S_FA:    return int'(cmpa_flag);
      S_FB:    return int'(cmpb_flag);
      S_EA:    return int'(oe_a);
      default: return int'(oe_b);
    endcase
  endfunction

  always @(negedge clk) begin
    for (int i = due_q.size() - 1; i >= 0; i--) begin
      if (due_q[i] == cyc) begin
        checks++;
        if (pick(sel_q[i]) != exp_q[i]) begin
          errors++;
          $display("FAIL %s at cycle %0d sel %0d: actual=%0d expected=%0d",
                   req_q[i], cyc, sel_q[i], pick(sel_q[i]), exp_q[i]);
        end
        due_q.delete(i); sel_q.delete(i); exp_q.delete(i); req_q.delete(i);
      end
    end
  end

  task automatic expect_at(input int k, input int sel, input int exp, input string req);
    due_q.push_back(t0 + k); sel_q.push_back(sel); exp_q.push_back(exp); req_q.push_back(req);
  endtask

  task automatic expect_next(input int sel, input int exp, input string req);
    due_q.push_back(cyc + 1); sel_q.push_back(sel); exp_q.push_back(exp); req_q.push_back(req);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    tick = 1'b0; wr_en = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_run();
    tick = 1'b1;
    t0 = cyc;
  endtask

  task automatic wait_k(input int k);
    while (cyc < t0 + k) @(negedge clk);
  endtask

  task automatic finish_run(input int k);
    wait_k(k);
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    expect_next(S_CNT, 0, "R1"); expect_next(S_OA, 0, "R1"); expect_next(S_OB, 0, "R1");
    expect_next(S_OVF, 0, "R1"); expect_next(S_FA, 0, "R1"); expect_next(S_FB, 0, "R1");
    expect_next(S_EA, 0, "R1"); expect_next(S_EB, 0, "R1");
    repeat (5) @(negedge clk);
    // R2 counting only on strobe cycles
    expect_next(S_CNT, 0, "R2");
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    expect_next(S_CNT, 3, "R2");
    repeat (2) @(negedge clk);

    // Normal mode, channel A toggles (R3, R8, R9)
    do_reset();
    wr(2'd1, 8'd10); wr(2'd0, 8'h10);
    start_run();
    expect_at(1, S_EA, 1, "R9");
    expect_at(10, S_FA, 0, "R8"); expect_at(11, S_FA, 1, "R8");
    expect_at(10, S_OA, 0, "R9"); expect_at(11, S_OA, 1, "R9");
    expect_at(255, S_CNT, 255, "R3"); expect_at(255, S_OVF, 0, "R3");
    expect_at(256, S_CNT, 0, "R3"); expect_at(256, S_OVF, 1, "R3");
    expect_at(267, S_OA, 0, "R9");
    expect_at(301, S_FA, 0, "R8"); expect_at(301, S_OVF, 1, "R8");
    wait_k(100); wr(2'd3, 8'h02);
    expect_at(150, S_FA, 0, "R8");
    wait_k(300); wr(2'd3, 8'h02);
    finish_run(301);

    // Reserved mode acts as normal, immediate compare (R3, R7)
    do_reset();
    wr(2'd0, 8'h06); wr(2'd1, 8'd3);
    start_run();
    expect_at(3, S_FA, 0, "R7"); expect_at(4, S_FA, 1, "R7");
    expect_at(255, S_CNT, 255, "R3"); expect_at(256, S_CNT, 0, "R3");
    expect_at(256, S_OVF, 1, "R3");
    finish_run(256);

    // Clear-on-compare (R4, R9)
    do_reset();
    wr(2'd1, 8'd5); wr(2'd0, 8'h12);
    start_run();
    expect_at(5, S_CNT, 5, "R4"); expect_at(6, S_CNT, 0, "R4"); expect_at(7, S_CNT, 1, "R4");
    expect_at(5, S_FA, 0, "R4"); expect_at(6, S_FA, 1, "R4");
    expect_at(6, S_OA, 1, "R9"); expect_at(11, S_OA, 1, "R9"); expect_at(12, S_OA, 0, "R9");
    expect_at(20, S_OVF, 0, "R4");
    finish_run(20);

    // Fast PWM TOP 0xFF, buffered compare B (R5, R7, R10)
    do_reset();
    wr(2'd0, 8'h83); wr(2'd2, 8'd1);
    start_run();
    expect_at(1, S_FB, 1, "R7"); expect_at(1, S_OB, 0, "R10");
    expect_at(20, S_FB, 0, "R8");
    expect_at(255, S_OVF, 0, "R5"); expect_at(256, S_OVF, 1, "R5");
    expect_at(256, S_OB, 1, "R10"); expect_at(257, S_OB, 1, "R10");
    expect_at(257, S_FB, 0, "R7"); expect_at(258, S_FB, 1, "R7"); expect_at(258, S_OB, 0, "R10");
    wait_k(10); wr(2'd3, 8'h04);
    finish_run(258);

    // Fast PWM TOP = compare A (R5, R10)
    do_reset();
    wr(2'd1, 8'd9); wr(2'd2, 8'd4); wr(2'd0, 8'h87);
    start_run();
    expect_at(9, S_CNT, 9, "R5"); expect_at(9, S_OVF, 0, "R5");
    expect_at(10, S_CNT, 0, "R5"); expect_at(10, S_OVF, 1, "R5"); expect_at(10, S_FA, 1, "R5");
    expect_at(5, S_OB, 0, "R10"); expect_at(10, S_OB, 1, "R10");
    expect_at(14, S_OB, 1, "R10"); expect_at(15, S_OB, 0, "R10");
    finish_run(15);

    // Phase-correct TOP = compare A, buffered B update (R6, R7, R11)
    do_reset();
    wr(2'd1, 8'd6); wr(2'd2, 8'd2); wr(2'd0, 8'h85);
    start_run();
    expect_at(1, S_OVF, 1, "R6");
    expect_at(3, S_OB, 0, "R11");
    expect_at(6, S_CNT, 6, "R6"); expect_at(7, S_CNT, 5, "R6");
    expect_at(12, S_CNT, 0, "R6"); expect_at(13, S_CNT, 1, "R6");
    expect_at(12, S_OVF, 0, "R6"); expect_at(13, S_OVF, 1, "R6");
    expect_at(8, S_OB, 0, "R7"); expect_at(9, S_OB, 1, "R7");
    expect_at(16, S_OB, 1, "R11"); expect_at(17, S_OB, 0, "R11");
    wait_k(3); wr(2'd3, 8'h08);
    wait_k(4); wr(2'd2, 8'd4);
    finish_run(17);

    // Phase-correct with compare B equal to TOP (R11, R12)
    do_reset();
    wr(2'd1, 8'd6); wr(2'd2, 8'd6); wr(2'd0, 8'h85);
    start_run();
    expect_at(5, S_EA, 0, "R11"); expect_at(5, S_EB, 1, "R11");
    expect_at(6, S_OB, 0, "R12"); expect_at(7, S_OB, 1, "R12"); expect_at(7, S_FB, 1, "R12");
    expect_at(18, S_OB, 1, "R12"); expect_at(19, S_OB, 0, "R12");
    wait_k(10); wr(2'd0, 8'hC5);
    wait_k(20); wr(2'd0, 8'h45);
    expect_next(S_EB, 0, "R11");
    finish_run(22);

    repeat (2) @(negedge clk);
    for (int i = 0; i < due_q.size(); i++) begin
      checks++; errors++;
      $display("FAIL %s: actual=unchecked expected=checked at cycle %0d", req_q[i], due_q[i]);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule